// File: doc/BRIEF.md
# At-Speed Scan Capture Clock Controller

This block drives the test clock of a scan-inserted design. While scan enable is high, the block passes the slow clock from the tester, so the scan chains can be loaded and unloaded at tester speed. When scan enable falls and the block is not in stuck-at mode, it closes the slow path. It then carves a burst of one to four full pulses out of a fast clock that runs all the time. Two pulses give the launch and capture cycles of a launch-on-capture transition test. Three or four pulses serve sequential multi-cycle patterns.

In stuck-at mode the fast path is never opened, and the output follows only the slow clock. A done flag, resynchronized into the slow domain, tells the tester that the burst has ended. The flag clears after scan enable is raised again. The slow and fast paths are never enabled at the same time. Each enable changes only while its own clock is low.

Top module: `atspeed_clk_ctrl`

## Requirements
- R1: While scan_en_i is high and no burst is in progress, every rising edge of test_clk_o comes from slow_clk_i, and the count of rising edges on test_clk_o equals the count on slow_clk_i.
- R2: When scan_en_i falls with stuck_mode_i low, test_clk_o carries exactly pulse_sel_i+1 pulses. The slow path is gated off during the burst, and pulse_sel_i=1 gives the two-pulse launch/capture pair.
- R3: The four pulse_sel_i codes 0, 1, 2 and 3 give bursts of 1, 2, 3 and 4 fast pulses.
- R4: The gate enable of each path changes only while that path's clock is low, so every burst pulse is a complete high phase of the free-running fast_clk_i.
- R5: With stuck_mode_i high, no fast pulse is issued. test_clk_o follows slow_clk_i even while scan_en_i is low, and done_o stays 0.
- R6: The fast gate opens only after the slow gate is seen closed in the fast domain, and only after at least one idle fast cycle. At least one idle fast cycle also follows the last pulse.
- R7: done_o rises after the last burst pulse, about two slow_clk_i edges later. It returns to 0 after scan_en_i is raised again.
- R8: After the burst, no further fast pulses appear until scan_en_i has been raised and dropped again. A change of pulse_sel_i in that interval has no effect.
- R9: While rst_ni is low (asynchronous, active low), done_o is 0, the fast gate is closed and test_clk_o follows slow_clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk_i | input | 1 | Free-running at-speed clock |
| slow_clk_i | input | 1 | Tester-supplied shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scan_en_i | input | 1 | High for shift; its fall triggers capture |
| stuck_mode_i | input | 1 | High selects stuck-at mode (slow clock only) |
| pulse_sel_i | input | 2 | Burst length minus one |
| test_clk_o | output | 1 | Gated test clock to the scan flops |
| done_o | output | 1 | Burst finished, in the slow domain |

## Verification
Once scan enable falls, the slow gate closes at the next falling edge of the slow clock. Two fast edges later the fast domain sees the slow gate closed, and after one idle fast cycle the burst of pulse_sel_i+1 pulses runs. The whole burst therefore lands well under 500 ns after the trigger. done_o follows about two slow edges (400 ns) later. After scan enable is raised again, the slow path reopens and done_o clears within about 700 ns. The bench changes its inputs just after a rising slow edge. It counts test clock edges over fixed windows of 1000 to 1500 ns, which cover these latencies, and it samples done_o only at the end of a window.

// File: rtl/atclk_pkg.sv
package atclk_pkg;
  typedef enum logic [1:0] {
    ST_SHIFT = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2,
    ST_DONE  = 2'd3
  } burst_st_e;
endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/clk_gate.sv
// Enable retimed on the falling edge: it changes only while clk_i is low.
module clk_gate #(
  parameter logic RST_EN = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_o,
  output logic gclk_o
);
  logic en_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST_EN;
    else         en_q <= en_i;
  end

  assign en_o   = en_q;
  assign gclk_o = clk_i & en_q;

  always @(en_q) begin
    if (rst_ni) begin
      p_gate_low_r4: assert (!clk_i) else $error("R4: gate enable moved while clock high");
    end
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import atclk_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CNT_W = $clog2((1 << SEL_W) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             se_i,
  input  logic             stuck_i,
  input  logic             slow_off_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             gate_en_o,
  output logic             busy_o,
  output logic             done_o
);
  burst_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_SHIFT: if (!se_i && !stuck_i) begin
        st_d  = ST_WAIT;
        cnt_d = {{(CNT_W-SEL_W){1'b0}}, sel_i} + CNT_W'(1);
      end
      ST_WAIT: begin
        if (se_i)            st_d = ST_SHIFT;
        else if (slow_off_i) st_d = ST_BURST;
      end
      ST_BURST: begin
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) st_d = ST_DONE;
      end
      ST_DONE: if (se_i) st_d = ST_SHIFT;
      default: st_d = ST_SHIFT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_SHIFT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign gate_en_o = (st_q == ST_BURST);
  assign busy_o    = (st_q != ST_SHIFT);
  assign done_o    = (st_q == ST_DONE);

  p_cnt_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_BURST |-> cnt_q != '0);
  p_burst_after_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_en_o) |-> $past(st_q) == ST_WAIT && $past(slow_off_i));
  p_stuck_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_SHIFT && stuck_i |=> !gate_en_o);
  p_done_from_burst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(st_q) == ST_BURST);
  p_no_rerun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DONE && !se_i |=> st_q == ST_DONE);
endmodule

// File: rtl/atspeed_clk_ctrl.sv
module atspeed_clk_ctrl #(
  parameter int SEL_W   = 2,
  parameter int SYNC_ST = 2
) (
  input  logic             fast_clk_i,
  input  logic             slow_clk_i,
  input  logic             rst_ni,
  input  logic             scan_en_i,
  input  logic             stuck_mode_i,
  input  logic [SEL_W-1:0] pulse_sel_i,
  output logic             test_clk_o,
  output logic             done_o
);
  logic se_f, stuck_f, slow_off_f;
  logic fast_gate_en, busy_f, done_f;
  logic busy_s, slow_en_d, slow_en_q, fast_en_q;
  logic slow_g, fast_g;

  // fast domain inputs
  scan_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b1)) u_se_sync (
    .clk_i(fast_clk_i), .rst_ni(rst_ni), .d_i(scan_en_i), .q_o(se_f));
  scan_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b0)) u_stuck_sync (
    .clk_i(fast_clk_i), .rst_ni(rst_ni), .d_i(stuck_mode_i), .q_o(stuck_f));
  scan_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b0)) u_off_sync (
    .clk_i(fast_clk_i), .rst_ni(rst_ni), .d_i(~slow_en_q), .q_o(slow_off_f));

  burst_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk_i(fast_clk_i), .rst_ni(rst_ni), .se_i(se_f), .stuck_i(stuck_f),
    .slow_off_i(slow_off_f), .sel_i(pulse_sel_i),
    .gate_en_o(fast_gate_en), .busy_o(busy_f), .done_o(done_f));

  // slow domain
  scan_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b0)) u_busy_sync (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .d_i(busy_f), .q_o(busy_s));
  scan_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b0)) u_done_sync (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .d_i(done_f), .q_o(done_o));

  assign slow_en_d = (scan_en_i | stuck_mode_i) & ~busy_s;

  clk_gate #(.RST_EN(1'b1)) u_slow_gate (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .en_i(slow_en_d),
    .en_o(slow_en_q), .gclk_o(slow_g));
  clk_gate #(.RST_EN(1'b0)) u_fast_gate (
    .clk_i(fast_clk_i), .rst_ni(rst_ni), .en_i(fast_gate_en),
    .en_o(fast_en_q), .gclk_o(fast_g));

  assign test_clk_o = slow_g | fast_g;

  p_paths_exclusive_r6: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    fast_en_q |-> !slow_en_q);
  p_reset_gate_r9: assert property (@(posedge fast_clk_i)
    !rst_ni |-> !fast_en_q && !done_o);
endmodule

// File: tb/tb_atspeed_clk_ctrl.sv
`timescale 1ns/1ps
module tb_atspeed_clk_ctrl;
  logic fast_clk = 1'b0, slow_clk = 1'b0;
  logic rst_n = 1'b0, se = 1'b1, stuck = 1'b0;
  logic [1:0] sel = 2'd1;
  logic tclk, done;
  int tcnt = 0, scnt = 0;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  atspeed_clk_ctrl dut (
    .fast_clk_i(fast_clk), .slow_clk_i(slow_clk), .rst_ni(rst_n),
    .scan_en_i(se), .stuck_mode_i(stuck), .pulse_sel_i(sel),
    .test_clk_o(tclk), .done_o(done));

  always #10 fast_clk = ~fast_clk;                 // 50 MHz
  initial begin #5; forever #100 slow_clk = ~slow_clk; end

  always @(posedge tclk)     tcnt++;
  always @(posedge slow_clk) scnt++;

  // {stuck, sel[1:0], expected fast pulses[2:0]}; stuck rows expect the slow count
  localparam logic [5:0] VEC [0:5] = '{
    {1'b0, 2'd1, 3'd2}, {1'b0, 2'd0, 3'd1}, {1'b0, 2'd2, 3'd3},
    {1'b0, 2'd3, 3'd4}, {1'b1, 2'd3, 3'd0}, {1'b0, 2'd1, 3'd2}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic shift_window(input string req);
    int t0, s0;
    @(posedge slow_clk); #1;
    t0 = tcnt; s0 = scnt;
    #1000;
    chk(req, tcnt - t0, scnt - s0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int t0, s0;
    #15;
    chk("R9 done in reset", int'(done), 0);
    shift_window("R9 slow clock in reset");
    rst_n = 1'b1;
    #1000;
    shift_window("R1 shift follows slow");

    for (int i = 0; i < 6; i++) begin
      stuck = VEC[i][5];
      sel   = VEC[i][4:3];
      #1000;
      chk("R7 done low before trigger", int'(done), 0);
      @(posedge slow_clk); #1;
      t0 = tcnt; s0 = scnt;
      se = 1'b0;
      #1500;
      if (stuck) begin
        chk("R5 stuck follows slow", tcnt - t0, scnt - s0);
        chk("R5 stuck no done", int'(done), 0);
      end else begin
        chk("R2 R3 burst pulse count", tcnt - t0, int'(VEC[i][2:0]));
        chk("R7 done after burst", int'(done), 1);
      end
      @(posedge slow_clk); #1;
      se = 1'b1;
      #1000;
      chk("R7 done cleared", int'(done), 0);
      shift_window("R1 shift after capture");
    end

    // R8: sel change after burst has no effect
    stuck = 1'b0; sel = 2'd1;
    #1000;
    @(posedge slow_clk); #1;
    t0 = tcnt;
    se = 1'b0;
    #1500;
    chk("R2 launch/capture pair", tcnt - t0, 2);
    sel = 2'd3;
    #1000;
    chk("R8 no pulses after sel change", tcnt - t0, 2);
    chk("R7 done held", int'(done), 1);

    // R9: reset from the done state
    rst_n = 1'b0;
    #50;
    chk("R9 reset clears done", int'(done), 0);
    se = 1'b1;
    #30;
    rst_n = 1'b1;
    #1500;
    shift_window("R9 shift after reset");

    finished = 1'b1;
    summary();
  end
endmodule